// File: doc/BRIEF.md
# Dual-Channel Row Address Scanner

This block selects one of thirteen address rows on one of two printheads. A four-bit row code is turned into a one-hot row enable, which goes to head A or to head B. The row code comes from one of two places. An internal fourteen-position up/down counter can supply it. It walks a reflected-code order in which adjacent positions differ by one bit. The other source is the four select pins, read as a direct code.

A mode input picks the source. In counter mode, select bit 0 is the counter clock and bit 1 is an active-low counter clear. Bit 2 sets the direction, with high meaning up. In direct mode, the select bits S3..S0 are the code C3..C0. A channel-select input picks the head, and an active-low channel enable blanks both heads.

All control inputs are asynchronous to the block clock. Each one passes through a synchronizer. A change at a pin therefore reaches the row outputs within SYNC_STAGES+2 clock cycles. The row outputs are registered, so they do not glitch.

Top module: `head_row_scanner`

## Requirements
- R1: In counter mode with bit 1 high and bit 2 high, each rising edge of select bit 0 moves the counter one position up. The order is 0000, 0001, 0011, 0010, 0110, 0111, 0101, 0100, 1100, 1101, 1111, 1110, 1010, 1000, and then back to 0000.
- R2: In counter mode with bit 1 high and bit 2 low, each rising edge of select bit 0 moves the counter one position back along the same order, so 0000 steps to 1000.
- R3: In counter mode, a low level on select bit 1 clears the counter to 0000. While bit 1 stays low, edges on bit 0 have no effect.
- R4: The counter keeps its position while there is no rising edge on bit 0, and also while the block is in direct mode.
- R5: Row k (k = 1..13, bit k-1 of a row output) is active for the code at position k of the R1 order.
- R6: Codes 0000, 1001 and 1011 activate no row.
- R7: Channel select low drives the rows to head A. Channel select high drives them to head B. The unselected head's rows stay all zero.
- R8: Channel enable high forces every row of both heads to zero.
- R9: While reset is asserted, both row outputs are zero and the counter is at 0000.
- R10: At most one row of the 26 outputs is active in any cycle.
- R11: The counter never holds 1001 or 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cnt_mode_i | input | 1 | 1: internal counter supplies the code; 0: select pins supply it |
| sel_i | input | 4 | Select pins S3..S0 (counter clock, clear, direction in counter mode) |
| chan_b_i | input | 1 | 0 selects head A, 1 selects head B |
| chan_en_n_i | input | 1 | Active-low channel enable |
| rows_a_o | output | 13 | One-hot row enables, head A |
| rows_b_o | output | 13 | One-hot row enables, head B |

## Verification
The checker runs on every cycle. It checks that at most one of the 26 rows is active, and that the heads never conflict. It checks that a disabled enable blanks both heads. The counter must never hold an off-sequence code, must clear while the clear pin is low, and must hold without a clock edge. The exact up and down orders and their wrap points cannot be seen by a single-cycle property. The same is true of the decoder's code-to-row mapping and of the count being kept across a trip through direct mode. The bench's directed scenarios show those by walking the full sequence and all sixteen direct codes.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  localparam int CODE_W   = 4;
  localparam int NUM_ROWS = 13;
  // binary index that closes the sequence (all-ones maps to 1000)
  localparam int TOP_IDX  = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0]   code_t;
  typedef logic [NUM_ROWS-1:0] rows_t;

  function automatic code_t to_gray(input code_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic code_t from_gray(input code_t g);
    code_t b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/row_scan_sync.sv
module row_scan_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else begin
      pipe_q[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/row_scan_step.sv
module row_scan_step
  import row_scan_pkg::*;
(
  input  code_t cur,
  input  logic  up,
  output code_t nxt
);
  localparam code_t LAST = code_t'(NUM_ROWS - 1);
  localparam code_t TOP  = code_t'(TOP_IDX);

  code_t idx;

  always_comb begin
    idx = from_gray(cur);
    if (idx == TOP) nxt = up ? '0 : to_gray(LAST);
    else if (idx > LAST) nxt = '0;            // off-sequence: recover
    else if (up) nxt = (idx == LAST) ? to_gray(TOP) : to_gray(idx + 1'b1);
    else nxt = (idx == '0) ? to_gray(TOP) : to_gray(idx - 1'b1);
  end
endmodule

// File: rtl/row_scan_decode.sv
module row_scan_decode
  import row_scan_pkg::*;
(
  input  code_t code,
  output rows_t rows
);
  code_t idx;
  assign idx = from_gray(code);

  for (genvar j = 0; j < NUM_ROWS; j++) begin : g_row
    if (j == NUM_ROWS - 1) begin : g_last
      assign rows[j] = (idx == code_t'(TOP_IDX));
    end else begin : g_mid
      assign rows[j] = (idx == code_t'(j + 1));
    end
  end
endmodule

// File: rtl/head_row_scanner.sv
module head_row_scanner
  import row_scan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                cnt_mode_i,
  input  logic [CODE_W-1:0]   sel_i,
  input  logic                chan_b_i,
  input  logic                chan_en_n_i,
  output logic [NUM_ROWS-1:0] rows_a_o,
  output logic [NUM_ROWS-1:0] rows_b_o
);
  localparam int CTL_W = CODE_W + 3;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= '0;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [CTL_W-1:0] ctl_s;
  code_t sel_s;
  logic  mode_s, chan_b_s, en_n_s;

  row_scan_sync #(
    .W(CTL_W), .STAGES(SYNC_STAGES),
    .RST_VAL({1'b1, {(CTL_W-1){1'b0}}})
  ) u_sync (
    .clk(clk_i), .rst_n(rst_n),
    .d({chan_en_n_i, chan_b_i, cnt_mode_i, sel_i}),
    .q(ctl_s)
  );
  assign {en_n_s, chan_b_s, mode_s, sel_s} = ctl_s;

  // counter clock edge detect
  logic s0_prev_q, s0_rise;
  assign s0_rise = sel_s[0] & ~s0_prev_q;

  code_t cnt_q, cnt_d, step_code, dec_code;
  rows_t dec_rows;
  rows_t rows_a_d, rows_b_d;

  row_scan_step u_step (.cur(cnt_q), .up(sel_s[2]), .nxt(step_code));

  always_comb begin
    cnt_d = cnt_q;
    if (mode_s) begin
      if (!sel_s[1])    cnt_d = '0;
      else if (s0_rise) cnt_d = step_code;
    end
  end

  assign dec_code = mode_s ? cnt_q : sel_s;

  row_scan_decode u_dec (.code(dec_code), .rows(dec_rows));

  always_comb begin
    rows_a_d = '0;
    rows_b_d = '0;
    if (!en_n_s) begin
      if (chan_b_s) rows_b_d = dec_rows;
      else          rows_a_d = dec_rows;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      s0_prev_q <= 1'b0;
      cnt_q     <= '0;
      rows_a_o  <= '0;
      rows_b_o  <= '0;
    end else begin
      s0_prev_q <= sel_s[0];
      cnt_q     <= cnt_d;
      rows_a_o  <= rows_a_d;
      rows_b_o  <= rows_b_d;
    end
  end
endmodule

// File: rtl/row_scan_checker.sv
module row_scan_checker
  import row_scan_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input code_t cnt,
  input logic  mode,
  input logic  clr_n,
  input logic  rise,
  input logic  en_n,
  input rows_t rows_a,
  input rows_t rows_b
);
  AST_ONE_ROW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rows_a, rows_b})); // R10
  AST_HEADS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((|rows_a) && (|rows_b))); // R7
  AST_DISABLE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> (rows_a == '0 && rows_b == '0)); // R8
  AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 4'b1001 && cnt != 4'b1011)); // R11
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !clr_n) |=> (cnt == '0)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode || (clr_n && !rise)) |=> $stable(cnt)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (rows_a == '0 && rows_b == '0 && cnt == '0)); // R9
endmodule

bind head_row_scanner row_scan_checker u_row_scan_checker (
  .clk(clk_i), .rst_n(rst_n), .cnt(cnt_q), .mode(mode_s),
  .clr_n(sel_s[1]), .rise(s0_rise), .en_n(en_n_s),
  .rows_a(rows_a_o), .rows_b(rows_b_o)
);

// File: tb/test_head_row_scanner.sv
module test_head_row_scanner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_mode = 1'b0;
  logic [3:0]  sel = 4'b0000;
  logic        chan_b = 1'b0;
  logic        chan_en_n = 1'b1;
  logic [12:0] rows_a, rows_b;

  int checks = 0;
  int fails  = 0;
  logic [3:0] seq [14];
  int pos;

  always #10 clk = ~clk;

  head_row_scanner i_head_row_scanner (
    .clk_i(clk), .rst_n_i(rst_n), .cnt_mode_i(cnt_mode), .sel_i(sel),
    .chan_b_i(chan_b), .chan_en_n_i(chan_en_n),
    .rows_a_o(rows_a), .rows_b_o(rows_b)
  );

  function automatic logic [12:0] pos_rows(input int p);
    return (p == 0) ? 13'd0 : (13'd1 << (p - 1));
  endfunction

  function automatic logic [12:0] code_rows(input logic [3:0] c);
    for (int k = 1; k < 14; k++) if (seq[k] == c) return 13'd1 << (k - 1);
    return 13'd0;
  endfunction

  task automatic settle();
    repeat (6) @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input logic [12:0] exp_a, input logic [12:0] exp_b);
    checks++;
    if (rows_a !== exp_a || rows_b !== exp_b) begin
      fails++;
      $display("FAIL %s: a=%b b=%b expected a=%b b=%b", req, rows_a, rows_b, exp_a, exp_b);
    end
  endtask

  task automatic pulse_s0();
    sel[0] = 1'b1; settle();
    sel[0] = 1'b0; settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (3) @(posedge clk); #5;
    check("R9 rows in reset", 13'd0, 13'd0);
    rst_n = 1'b1; settle();
    check("R9 after release, disabled", 13'd0, 13'd0);
  endtask

  task automatic t_direct();
    cnt_mode = 1'b0; chan_en_n = 1'b0; chan_b = 1'b0;
    for (int c = 0; c < 16; c++) begin
      sel = 4'(c); settle();
      if (c == 0 || c == 9 || c == 11) check("R6 empty code", 13'd0, 13'd0);
      else check("R5 direct decode head A", code_rows(4'(c)), 13'd0);
    end
  endtask

  task automatic t_channel();
    cnt_mode = 1'b0; chan_en_n = 1'b0; chan_b = 1'b1;
    for (int k = 1; k < 14; k += 4) begin
      sel = seq[k]; settle();
      check("R7 head B", 13'd0, pos_rows(k));
    end
    chan_b = 1'b0; settle();
    check("R7 back to head A", pos_rows(13), 13'd0);
  endtask

  task automatic t_enable();
    cnt_mode = 1'b0; sel = 4'b0111; chan_en_n = 1'b1;
    chan_b = 1'b0; settle(); check("R8 disabled A", 13'd0, 13'd0);
    chan_b = 1'b1; settle(); check("R8 disabled B", 13'd0, 13'd0);
    chan_en_n = 1'b0; settle(); check("R8 re-enabled", 13'd0, pos_rows(5));
    chan_b = 1'b0;
  endtask

  task automatic t_count_up();
    chan_en_n = 1'b0; chan_b = 1'b0;
    sel = 4'b0010; cnt_mode = 1'b1; settle();
    sel = 4'b0000; settle();  // clear
    sel = 4'b0110; settle();
    check("R1 start at 0000", 13'd0, 13'd0);
    for (int n = 1; n <= 14; n++) begin
      pulse_s0();
      check("R1 up step", pos_rows(n % 14), 13'd0);
    end
  endtask

  task automatic t_count_down();
    cnt_mode = 1'b1; sel = 4'b0010; settle();
    pos = 0;
    for (int n = 0; n < 14; n++) begin
      pulse_s0();
      pos = (pos == 0) ? 13 : pos - 1;
      check("R2 down step", pos_rows(pos), 13'd0);
    end
  endtask

  task automatic t_count_clear();
    cnt_mode = 1'b1; sel = 4'b0110; settle();
    pulse_s0(); pulse_s0(); pulse_s0();
    check("R1 before clear", pos_rows(3), 13'd0);
    sel = 4'b0100; settle();
    check("R3 cleared", 13'd0, 13'd0);
    sel = 4'b0101; settle(); sel = 4'b0100; settle();
    check("R3 edge ignored while clear", 13'd0, 13'd0);
    sel = 4'b0110; settle();
    pulse_s0();
    check("R3 restart at row 1", pos_rows(1), 13'd0);
  endtask

  task automatic t_hold();
    cnt_mode = 1'b1; sel = 4'b0110; settle();
    pulse_s0(); pulse_s0();
    check("R4 at row 3", pos_rows(3), 13'd0);
    repeat (20) @(posedge clk); #5;
    check("R4 holds without edge", pos_rows(3), 13'd0);
    cnt_mode = 1'b0; sel = 4'b0000; settle();
    check("R4 direct mode shows pins", 13'd0, 13'd0);
    sel = 4'b0001; settle(); sel = 4'b0000; settle();
    sel = 4'b0110; settle();
    check("R5 direct 0110 row 4", pos_rows(4), 13'd0);
    cnt_mode = 1'b1; settle();
    check("R4 count kept across direct mode", pos_rows(3), 13'd0);
  endtask

  initial begin
    for (int i = 0; i < 13; i++) seq[i] = 4'(i ^ (i >> 1));
    seq[13] = 4'b1000;
    t_reset();
    t_direct();
    t_channel();
    t_enable();
    t_count_up();
    t_count_down();
    t_count_clear();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule